// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral sitting on a simple word-addressed bus. Software drives the lines through an output latch that can be loaded whole or changed bit by bit through separate set and clear registers. These bit-level writes change only the selected lines, so no read-modify-write sequence is needed on the bus. A direction register decides which lines drive their pins. A parameter picks whether a 1 in that register means "drive" or "listen".

Line levels from the pins pass through a two-stage synchroniser before software sees them. Reading the set register can return the latch itself, so the value being driven stays visible even when a pin is pulled elsewhere. Two parameters change how bus words map onto lines. One reverses the bit numbering, so line n sits in bit WIDTH-1-n. The other swaps bytes for 16-bit and 32-bit widths.

The bus port is single-cycle. A write is taken at the rising edge when the write enable is high. Read data is a combinational function of the address and the current state.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset the output latch is zero and, when a direction register is configured, every line is an input, so all output enables are low.
- R2: Word offset 0 is the data register. A write loads the whole latch at the next edge. A read returns the pin levels, and a pin change reaches the read data only after the second rising edge following it.
- R3: A write to offset 1 (set) raises every line whose written bit is 1. All other lines keep their value.
- R4: A write to offset 2 (clear) lowers every line whose written bit is 1. All other lines keep their value.
- R5: With read-back enabled, a read of offset 1 returns the output latch, and a read of offset 2 returns zero.
- R6: In output-direction mode (DIR_MODE=1), a 1 written to offset 3 enables that line's output. Offset 3 reads back the same value.
- R7: In input-direction mode (DIR_MODE=2), a 1 at offset 3 makes the line an input, so after reset offset 3 reads all ones.
- R8: With MIRROR=1, line n is held in register bit WIDTH-1-n in every register.
- R9: With BYTE_SWAP=1 and a width of 16 or 32, bus byte k corresponds to register byte NB-1-k. Combined with MIRROR, bus bit 0 of a 16-bit instance reaches line 7.
- R10: Offsets above 3 read zero, and writes to them change neither the latch nor the output enables.
- R11: A read and a write of the same register in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data (combinational) |
| pin_in | input | WIDTH | Pin levels |
| pin_out | output | WIDTH | Per-line output value |
| pin_oe | output | WIDTH | Per-line output enable |

## Verification
A bit-level write and a read of the same register can fall in one cycle, because the port takes a write and presents read data for the same address. The bench raises the write enable on a set-register access and samples the read data just before the rising edge. At that point it must still show the old latch. After the edge it must show the updated one.

A pin change arriving between writes exercises the synchroniser. The bench checks that the change is absent from the data read after the first edge and present after the second.

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl #(
  parameter int WIDTH        = 32,
  parameter int ADDR_W       = 3,
  parameter int HAS_SETCLR   = 1,
  parameter int DIR_MODE     = 1,
  parameter int SET_READBACK = 1,
  parameter int MIRROR       = 0,
  parameter int BYTE_SWAP    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam int NB = WIDTH / 8;
  localparam bit SWAP_EN = (BYTE_SWAP != 0) && (WIDTH == 16 || WIDTH == 32);
  localparam logic [ADDR_W-1:0] OFF_DAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(3);

  function automatic logic [WIDTH-1:0] swap_bytes(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (SWAP_EN)
      for (int b = 0; b < NB; b++) r[8*b +: 8] = v[8*(NB-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] mirror_bits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (MIRROR != 0)
      for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] latch_q, oe_q, sync1_q, sync2_q, wr_line;

  assign wr_line = mirror_bits(swap_bytes(bus_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      oe_q    <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (bus_we) begin
        case (bus_addr)
          OFF_DAT: latch_q <= wr_line;
          OFF_SET: if (HAS_SETCLR != 0) latch_q <= latch_q | wr_line;
          OFF_CLR: if (HAS_SETCLR != 0) latch_q <= latch_q & ~wr_line;
          OFF_DIR: if (DIR_MODE != 0) oe_q <= (DIR_MODE == 1) ? wr_line : ~wr_line;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_DAT: bus_rdata = swap_bytes(mirror_bits(sync2_q));
      OFF_SET: if (HAS_SETCLR != 0 && SET_READBACK != 0)
                 bus_rdata = swap_bytes(mirror_bits(latch_q));
      OFF_DIR: if (DIR_MODE == 1) bus_rdata = swap_bytes(mirror_bits(oe_q));
               else if (DIR_MODE == 2) bus_rdata = swap_bytes(mirror_bits(~oe_q));
      default: ;
    endcase
  end

  assign pin_out = latch_q;
  assign pin_oe  = (DIR_MODE == 0) ? '1 : oe_q;

  a_r3_set_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_SET) |=> ((pin_out & $past(pin_out)) == $past(pin_out)));

  a_r4_clr_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CLR) |=> ((pin_out & ~$past(pin_out)) == '0));

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out));

  a_r6_oe_only_by_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_DIR) |=> $stable(pin_oe));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > OFF_DIR) |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_mmio_ctrl.sv
module test_gpio_mmio_ctrl;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [2:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 0, b_we = 0;
  logic [31:0] a_wdata = '0, a_rdata, a_pin_in = '0, a_out, a_oe;
  logic [15:0] b_wdata = '0, b_rdata, b_pin_in = '0, b_out, b_oe;

  gpio_mmio_ctrl i_gpio_mmio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_we(a_we),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .pin_in(a_pin_in),
    .pin_out(a_out), .pin_oe(a_oe));

  gpio_mmio_ctrl #(.WIDTH(16), .DIR_MODE(2), .MIRROR(1), .BYTE_SWAP(1)) i_gpio_mmio_ctrl_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .pin_in(b_pin_in),
    .pin_out(b_out), .pin_oe(b_oe));

  int errors = 0, checks = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk); a_addr = ad; a_wdata = d; a_we = 1;
    @(negedge clk); a_we = 0;
  endtask

  task automatic rd_a(input logic [2:0] ad, output logic [31:0] d);
    a_addr = ad; #1; d = a_rdata;
  endtask

  task automatic wr_b(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk); b_addr = ad; b_wdata = d; b_we = 1;
    @(negedge clk); b_we = 0;
  endtask

  task automatic rd_b(input logic [2:0] ad, output logic [15:0] d);
    b_addr = ad; #1; d = b_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] r; logic [15:0] rb;
    check("R1 latch after reset", a_out, 0);
    check("R1 oe after reset", a_oe, 0);
    rd_a(3, r); check("R6 dir read after reset", r, 0);
    check("R1 oe after reset (b)", b_oe, 0);
    rd_b(3, rb); check("R7 input-mode dir reads ones", rb, 16'hFFFF);
  endtask

  task automatic t_latch;
    logic [31:0] r;
    wr_a(0, 32'hA5A5_0F0F); check("R2 data write", a_out, 32'hA5A5_0F0F);
    rd_a(1, r); check("R5 set readback", r, 32'hA5A5_0F0F);
    rd_a(2, r); check("R5 clear reads zero", r, 0);
    wr_a(1, 32'h0000_00F0); check("R3 set write", a_out, 32'hA5A5_0FFF);
    wr_a(2, 32'hA500_000F); check("R4 clear write", a_out, 32'h00A5_0FF0);
  endtask

  task automatic t_dir;
    logic [31:0] r;
    wr_a(3, 32'h0000_FFFF); check("R6 oe", a_oe, 32'h0000_FFFF);
    rd_a(3, r); check("R6 dir readback", r, 32'h0000_FFFF);
  endtask

  task automatic t_sync;
    logic [31:0] r;
    @(negedge clk); a_pin_in = 32'h1234_5678;
    @(negedge clk); rd_a(0, r); check("R2 not yet visible after one edge", r, 0);
    @(negedge clk); rd_a(0, r); check("R2 visible after two edges", r, 32'h1234_5678);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    wr_a(5, 32'hFFFF_FFFF);
    check("R10 latch unchanged", a_out, 32'h00A5_0FF0);
    check("R10 oe unchanged", a_oe, 32'h0000_FFFF);
    rd_a(5, r); check("R10 unmapped read", r, 0);
    rd_a(7, r); check("R10 unmapped read top", r, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] r;
    @(negedge clk); a_addr = 1; a_wdata = 32'hF000_0000; a_we = 1;
    #1; r = a_rdata; check("R11 read before edge shows old", r, 32'h00A5_0FF0);
    @(negedge clk); a_we = 0;
    #1; r = a_rdata; check("R11 read after edge shows new", r, 32'hF0A5_0FF0);
  endtask

  task automatic t_mirror_swap;
    logic [15:0] rb;
    wr_b(0, 16'h0001); check("R9 bus bit0 to line 7", b_out, 16'h0080);
    wr_b(0, 16'h00F0); check("R8 mirrored lines", b_out, 16'h000F);
    rd_b(1, rb); check("R8 readback mapped", rb, 16'h00F0);
    wr_b(3, 16'hFFFE); check("R7 zero makes output", b_oe, 16'h0080);
    @(negedge clk); b_pin_in = 16'h0001;
    @(negedge clk); @(negedge clk);
    rd_b(0, rb); check("R9 pin line0 on bus", rb, 16'h0080);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_dir;
    t_sync;
    t_unmapped;
    t_same_cycle;
    t_mirror_swap;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule